// File: doc/BRIEF.md
# Port Input Debounce Filter

This block sits between the synchronized inputs of one eight-pin general-purpose port and everything that consumes them (the input register and the interrupt detector). A free-running prescaler divides the system clock down to a one-millisecond tick. A single count register, shared by every pin of the port, sets how many consecutive ticks a pin must hold a new level before its filtered output changes. A per-pin enable bit chooses between the filtered level and the raw level.

Configuration arrives through a write-only register strobe with a one-bit register select. A count write loads the low eight data bits. An enable write is masked: the upper half of the data word picks the pins to update, and the lower half supplies their new enable values. Pins that are not picked keep their enable. A count of zero disables filtering for the whole port, whatever the enable bits hold. The pin inputs and outputs are plain level signals with no handshake, because they carry a level every cycle rather than a stream of items.

Top module: `gpio_debounce_port`

## Requirements
- R1: During and after reset the count and all enables are 0, so every output bit equals its raw input bit.
- R2: The internal tick fires once every CLKS_PER_MS clock cycles, for one cycle, starting CLKS_PER_MS cycles after reset.
- R3: A write with cfg_we=1 and cfg_sel=0 loads cfg_wdata[7:0] into the single count register, from the next cycle on; the same count (1 to 255) applies to all eight pins.
- R4: A write with cfg_we=1 and cfg_sel=1 updates enable bit i to cfg_wdata[i] only when cfg_wdata[8+i] is 1; other enable bits keep their value.
- R5: A pin whose enable bit is 0 drives its output from its raw input in the same cycle, with no filtering.
- R6: When the count register holds 0, every output equals its raw input in the same cycle, even for pins whose enable bit is 1.
- R7: A filtered pin's output changes only on a tick, and only after the raw input has held the new level through N consecutive ticks, N being the count; the change is visible the cycle after the Nth tick.
- R8: If a filtered pin's raw input returns to the current output level before N ticks have passed, its tick run restarts from zero.
- R9: While a pin is bypassed its filtered level follows the raw input, so turning filtering on does not change the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe, one write per cycle it is high |
| cfg_sel | input | 1 | Register select: 0 = count, 1 = masked enable |
| cfg_wdata | input | 16 | Write data; [15:8] pin select and [7:0] values for enables, [7:0] for the count |
| raw_in | input | 8 | Synchronized raw pin levels |
| pin_out | output | 8 | Debounced (or bypassed) pin levels |

## Verification
The filter is tried with a clean level change held past the count, a change that returns to the old level for one cycle part way through its run, and a change on two pins at once with one of them later bypassed by a masked enable write. The clean change separates an early switch (checked after N-1 tick periods) from a late or missing one (checked after N periods); the one-cycle return tells a restarting run from one that keeps counting; the two-pin case shows the count is shared while enables are per pin. The count is driven to 0, 1 and 255 to tell bypass, single-tick and full-width behaviour apart, and filtering is switched on after a bypassed change to show the output does not jump.

// File: rtl/dbnc_pkg.sv
package dbnc_pkg;
  typedef enum logic {
    REG_COUNT  = 1'b0,
    REG_ENABLE = 1'b1
  } cfg_reg_e;
endpackage

// File: rtl/ms_tick_gen.sv
module ms_tick_gen #(
  parameter int CLKS_PER_MS = 50000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int W = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;

  generate
    if (CLKS_PER_MS <= 1) begin : g_every
      assign tick_o = rst_n;
    end else begin : g_div
      localparam logic [W-1:0] LAST = W'(CLKS_PER_MS - 1);
      logic [W-1:0] div_q;
      assign tick_o = (div_q == LAST);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      div_q <= '0;
        else if (tick_o) div_q <= '0;
        else             div_q <= div_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/dbnc_cfg_regs.sv
module dbnc_cfg_regs
  import dbnc_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int CNT_W    = 8,
  parameter int WDATA_W  = 2 * NUM_PINS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we_i,
  input  logic                sel_i,
  input  logic [WDATA_W-1:0]  wdata_i,
  output logic [NUM_PINS-1:0] en_o,
  output logic [CNT_W-1:0]    count_o
);
  logic [NUM_PINS-1:0] pick;
  logic [NUM_PINS-1:0] vals;

  assign pick = wdata_i[2*NUM_PINS-1:NUM_PINS];
  assign vals = wdata_i[NUM_PINS-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_o    <= '0;
      count_o <= '0;
    end else if (we_i) begin
      if (cfg_reg_e'(sel_i) == REG_COUNT) count_o <= wdata_i[CNT_W-1:0];
      else                                en_o    <= (en_o & ~pick) | (vals & pick);
    end
  end
endmodule

// File: rtl/dbnc_pin_filter.sv
module dbnc_pin_filter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ms_tick,
  input  logic             raw_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             out_o
);
  logic             bypass;
  logic             lvl_q;
  logic [CNT_W-1:0] run_q;
  logic             run_done;

  assign bypass   = !en_i || (limit_i == '0);
  assign run_done = ({1'b0, run_q} + 1'b1) >= {1'b0, limit_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      run_q <= '0;
    end else if (bypass) begin
      lvl_q <= raw_i;
      run_q <= '0;
    end else if (raw_i == lvl_q) begin
      run_q <= '0;
    end else if (ms_tick) begin
      if (run_done) begin
        lvl_q <= raw_i;
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign out_o = bypass ? raw_i : lvl_q;
endmodule

// File: rtl/gpio_debounce_port.sv
module gpio_debounce_port #(
  parameter int CLKS_PER_MS = 50000,
  parameter int NUM_PINS    = 8,
  parameter int CNT_W       = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic                    cfg_sel,
  input  logic [2*NUM_PINS-1:0]   cfg_wdata,
  input  logic [NUM_PINS-1:0]     raw_in,
  output logic [NUM_PINS-1:0]     pin_out
);
  logic                ms_tick;
  logic [NUM_PINS-1:0] en_q;
  logic [CNT_W-1:0]    count_q;

  ms_tick_gen #(.CLKS_PER_MS(CLKS_PER_MS)) tick_i (
    .clk   (clk),
    .rst_n (rst_n),
    .tick_o(ms_tick)
  );

  dbnc_cfg_regs #(.NUM_PINS(NUM_PINS), .CNT_W(CNT_W)) regs_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .we_i   (cfg_we),
    .sel_i  (cfg_sel),
    .wdata_i(cfg_wdata),
    .en_o   (en_q),
    .count_o(count_q)
  );

  generate
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      dbnc_pin_filter #(.CNT_W(CNT_W)) filt_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .ms_tick(ms_tick),
        .raw_i  (raw_in[p]),
        .en_i   (en_q[p]),
        .limit_i(count_q),
        .out_o  (pin_out[p])
      );
    end
  endgenerate
endmodule

// File: rtl/gpio_debounce_port_chk.sv
module gpio_debounce_port_chk #(
  parameter int CLKS_PER_MS = 50000,
  parameter int NUM_PINS    = 8,
  parameter int CNT_W       = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cfg_we,
  input logic                  cfg_sel,
  input logic [2*NUM_PINS-1:0] cfg_wdata,
  input logic [NUM_PINS-1:0]   raw_in,
  input logic [NUM_PINS-1:0]   pin_out,
  input logic                  ms_tick,
  input logic [NUM_PINS-1:0]   en_q,
  input logic [CNT_W-1:0]      count_q
);
  logic [31:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gap_q <= '0;
    else if (ms_tick) gap_q <= '0;
    else              gap_q <= gap_q + 1'b1;
  end

  // R2: tick spacing
  assert_tick_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ms_tick |-> (gap_q == 32'(CLKS_PER_MS - 1)));

  // R3: count load
  assert_count_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_sel) |=> (count_q == $past(cfg_wdata[CNT_W-1:0])));

  // R4: unselected enables are kept
  assert_mask_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel) |=>
      (((en_q ^ $past(en_q)) & ~$past(cfg_wdata[2*NUM_PINS-1:NUM_PINS])) == '0));

  // R5: disabled pins follow raw input
  assert_disabled_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_out ^ raw_in) & ~en_q) == '0);

  // R6: zero count bypasses all pins
  assert_zero_count_bypass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == '0) |-> (pin_out == raw_in));

  // R7: filtered outputs move only on a tick
  assert_change_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ms_tick && !cfg_we && count_q != '0) |=>
      (((pin_out ^ $past(pin_out)) & en_q) == '0));
endmodule

bind gpio_debounce_port gpio_debounce_port_chk #(
  .CLKS_PER_MS(CLKS_PER_MS),
  .NUM_PINS   (NUM_PINS),
  .CNT_W      (CNT_W)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_we   (cfg_we),
  .cfg_sel  (cfg_sel),
  .cfg_wdata(cfg_wdata),
  .raw_in   (raw_in),
  .pin_out  (pin_out),
  .ms_tick  (ms_tick),
  .en_q     (en_q),
  .count_q  (count_q)
);

// File: tb/gpio_debounce_port_tb_top.sv
module gpio_debounce_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MS         = 5;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } sb_item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [7:0]  raw_in = 8'hA5;
  logic [7:0]  pin_out;

  sb_item_t sb_q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_debounce_port #(.CLKS_PER_MS(MS), .NUM_PINS(8), .CNT_W(8)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_sel  (cfg_sel),
    .cfg_wdata(cfg_wdata),
    .raw_in   (raw_in),
    .pin_out  (pin_out)
  );

  // monitor: pops expectations at the falling edge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      sb_item_t it;
      it = sb_q.pop_front();
      n_cmp++;
      if (pin_out !== it.exp) begin
        n_bad++;
        $display("FAIL %s: pin_out=%02h expected=%02h", it.tag, pin_out, it.exp);
      end
    end
  end

  task automatic expect_out(input logic [7:0] exp, input string tag);
    sb_item_t it;
    it.exp = exp;
    it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic clks(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic cfg_write(input logic sel, input logic [15:0] data);
    cfg_sel   = sel;
    cfg_wdata = data;
    cfg_we    = 1'b1;
    @(posedge clk); #1;
    cfg_we    = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    clks(3);
    expect_out(8'hA5, "R1 output equals raw in reset");
    rst_n = 1'b1;
    clks(2);
    raw_in = 8'h3C;
    expect_out(8'h3C, "R1 R5 raw passes after reset");

    // shared count 3, pins 1 and 2 filtered
    cfg_write(1'b0, 16'h0003);
    cfg_write(1'b1, 16'hFF06);
    raw_in = 8'h3A;
    expect_out(8'h3C, "R7 filtered pins hold at once, R5 others follow");
    clks(9);
    expect_out(8'h3C, "R7 no change before 3 ticks");
    clks(5);
    expect_out(8'h3A, "R7 R3 change after 3 ticks on both pins");

    // one-cycle return restarts the run
    raw_in = 8'h38;
    clks(9);
    expect_out(8'h3A, "R8 holds before run ends");
    raw_in = 8'h3A;
    clks(1);
    raw_in = 8'h38;
    clks(9);
    expect_out(8'h3A, "R8 run restarted after glitch");
    clks(6);
    expect_out(8'h38, "R8 change after restarted run");

    // masked enable write: drop pin1, keep pin2
    cfg_write(1'b1, 16'h0200);
    raw_in = 8'h3E;
    expect_out(8'h3A, "R4 pin1 bypassed, pin2 still filtered");
    clks(15);
    expect_out(8'h3E, "R4 R7 pin2 changes after count");

    // count zero bypasses enabled pin
    cfg_write(1'b0, 16'h0000);
    raw_in = 8'h3A;
    expect_out(8'h3A, "R6 zero count bypasses enabled pin2");

    // re-enable filtering: no jump
    cfg_write(1'b0, 16'h0002);
    expect_out(8'h3A, "R9 no jump when filtering resumes");
    raw_in = 8'h3E;
    expect_out(8'h3A, "R9 pin2 filtered again");
    clks(4);
    expect_out(8'h3A, "R7 count 2 not reached after one tick");
    clks(5);
    expect_out(8'h3E, "R7 count 2 reached");

    // full-width count on pin0 only
    cfg_write(1'b0, 16'h00FF);
    cfg_write(1'b1, 16'hFF01);
    raw_in = 8'h3F;
    expect_out(8'h3E, "R3 count 255 holds at once");
    clks(254 * MS - 1);
    expect_out(8'h3E, "R3 count 255 not reached after 254 ticks");
    clks(MS);
    expect_out(8'h3F, "R3 count 255 reached");

    // count 1
    cfg_write(1'b0, 16'h0001);
    raw_in = 8'h3E;
    clks(MS);
    expect_out(8'h3E, "R7 count 1 changes on next tick");

    // reset clears enables and count
    rst_n = 1'b0;
    clks(2);
    rst_n = 1'b1;
    clks(1);
    raw_in = 8'hC1;
    expect_out(8'hC1, "R1 enables cleared by reset");

    clks(2);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule